// File: doc/BRIEF.md
# Three-Bus Register Datapath

An 8-bit datapath organised around three shared buses: two operand buses (A and B) and a single write-back bus (Z). Two registers sit on these buses. Each register has one write port, which takes its data from bus Z, and two read ports. Read port 0 feeds bus A and read port 1 feeds bus B. A bitwise function unit and an adder/subtractor take their first operand from bus A and their second from bus B. A one-position shifter sees only bus A. Each operator reaches bus Z through its own gated stage. A fourth gated stage places external input data on bus Z.

A read stage copies bus A to the external output. Every bus and the output stage keep their last value while no driver is enabled. All enables come from outside the block, so an external controller or the bench issues one micro-operation per clock. For example, one clock can read register 0 onto A and register 1 onto B, enable the adder onto Z and write Z back into register 0.

Top module: `tbd_datapath`

## Requirements
- R1: A synchronous reset clears both registers, all three bus hold values and the held output value to zero. After reset, with no enables active, the external output reads 0.
- R2: On a rising clock edge, a register whose write enable is high captures bus Z. A register whose write enable is low keeps its contents.
- R3: Register 0 drives bus A when its port-0 read enable is high and drives bus B when its port-1 read enable is high. The same holds for register 1. These paths are combinational, within the same cycle.
- R4: When no driver of a bus is enabled, the bus presents the value it last carried. A register written from an undriven bus Z therefore receives the last value placed on Z.
- R5: While the external load enable is high, bus Z carries the external input data.
- R6: While the external read enable is high, the external output equals bus A in the same cycle. While it is low, the output keeps the last value it passed.
- R7: With sub=0 the adder stage yields A+B. With sub=1 it yields A+~B+1, which is A−B. Both results are modulo 256 and the carry-out is dropped.
- R8: With shift-on=0 the shifter passes A unchanged. With shift-on=1, left=1 gives A shifted left by one with bit 0 filled by 0, and left=0 gives A shifted right by one with bit 7 filled by 0.
- R9: Bit i of the function unit's result is fn_sel[{A[i],B[i]}], with fn_sel[3:0] ordered as g3..g0. For example, 4'b1000 gives AND, 4'b0110 gives XOR and 4'b1110 gives OR.
- R10: At most one driver of any bus may be enabled in a cycle. Under that rule, the bus carries exactly the enabled driver's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ext_d_i | input | 8 | External data for the load stage |
| ext_q_o | output | 8 | External output from the read stage |
| fn_sel_i | input | 4 | Function unit truth table (g3..g0) |
| fn_en_i | input | 1 | Function unit stage drives bus Z |
| sh_on_i | input | 1 | Shifter shifts (1) or passes (0) |
| sh_left_i | input | 1 | Shift direction: 1 left, 0 right |
| sh_en_i | input | 1 | Shifter stage drives bus Z |
| sub_i | input | 1 | Adder stage subtracts when high |
| as_en_i | input | 1 | Adder stage drives bus Z |
| r0_wr_i | input | 1 | Register 0 write enable |
| r0_rda_i | input | 1 | Register 0 drives bus A |
| r0_rdb_i | input | 1 | Register 0 drives bus B |
| r1_wr_i | input | 1 | Register 1 write enable |
| r1_rda_i | input | 1 | Register 1 drives bus A |
| r1_rdb_i | input | 1 | Register 1 drives bus B |
| ext_ld_i | input | 1 | External load stage drives bus Z |
| ext_rd_i | input | 1 | Read stage copies bus A to the output |

## Verification
The assertions assume that the controller never enables two drivers on the same bus in one cycle. Under that rule each bus value is well defined, and the register write and bus hold properties can refer to a single source. The random stimulus keeps within the rule by choosing one source index per bus: none, register 0 or register 1 for buses A and B, and none or one of the four stages for bus Z. Only then does it turn on the matching enable. The directed cases set enables one at a time for the same reason.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
    parameter int unsigned DW = 8;

    localparam int unsigned Z_FN  = 0;
    localparam int unsigned Z_SH  = 1;
    localparam int unsigned Z_AS  = 2;
    localparam int unsigned Z_EXT = 3;
    localparam int unsigned Z_SRC = 4;
    localparam int unsigned RD_SRC = 2;

    typedef struct packed {
        logic [DW-1:0] r1;
        logic [DW-1:0] r0;
    } regs_t;
endpackage

// File: rtl/tbd_funcunit.sv
module tbd_funcunit #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   sel_i,
    output logic [W-1:0] y_o
);
    // each bit looks up the truth table entry indexed by its operand pair
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y_o[i] = sel_i[{a_i[i], b_i[i]}];
    end
endmodule

// File: rtl/tbd_shifter.sv
module tbd_shifter #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         on_i,
    input  logic         left_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        y_o = a_i;
        if (on_i) begin
            if (left_i) y_o = {a_i[W-2:0], 1'b0};
            else        y_o = {1'b0, a_i[W-1:1]};
        end
    end
endmodule

// File: rtl/tbd_addsub.sv
module tbd_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o
);
    logic [W-1:0] b_eff;
    logic [W-1:0] cin;
    assign b_eff = b_i ^ {W{sub_i}};
    assign cin   = {{(W-1){1'b0}}, sub_i};
    // carry-out falls off the W-bit result
    assign y_o   = a_i + b_eff + cin;
endmodule

// File: rtl/tbd_bus.sv
module tbd_bus #(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        en_i,
    input  logic [N-1:0][W-1:0] src_i,
    output logic [W-1:0]        bus_o
);
    logic [W-1:0] hold_d, hold_q;

    always_comb begin
        bus_o = hold_q;
        for (int k = 0; k < N; k++) begin
            if (en_i[k]) bus_o = src_i[k];
        end
        hold_d = bus_o;
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else     hold_q <= hold_d;
    end

    // R10
    one_driver_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(en_i) <= 1);

    // R4
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(|en_i) && !$past(rst)) |-> (bus_o == $past(bus_o)));
endmodule

// File: rtl/tbd_datapath.sv
module tbd_datapath
    import tbd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] ext_d_i,
    output logic [DW-1:0] ext_q_o,
    input  logic [3:0]    fn_sel_i,
    input  logic          fn_en_i,
    input  logic          sh_on_i,
    input  logic          sh_left_i,
    input  logic          sh_en_i,
    input  logic          sub_i,
    input  logic          as_en_i,
    input  logic          r0_wr_i,
    input  logic          r0_rda_i,
    input  logic          r0_rdb_i,
    input  logic          r1_wr_i,
    input  logic          r1_rda_i,
    input  logic          r1_rdb_i,
    input  logic          ext_ld_i,
    input  logic          ext_rd_i
);
    regs_t regs_d, regs_q;

    logic [DW-1:0] bus_a, bus_b, bus_z;
    logic [DW-1:0] fn_y, sh_y, as_y;

    logic [Z_SRC-1:0]           z_en;
    logic [Z_SRC-1:0][DW-1:0]   z_src;

    assign z_en[Z_FN]   = fn_en_i;
    assign z_en[Z_SH]   = sh_en_i;
    assign z_en[Z_AS]   = as_en_i;
    assign z_en[Z_EXT]  = ext_ld_i;
    assign z_src[Z_FN]  = fn_y;
    assign z_src[Z_SH]  = sh_y;
    assign z_src[Z_AS]  = as_y;
    assign z_src[Z_EXT] = ext_d_i;

    // operand buses: register port 0 -> A, port 1 -> B
    tbd_bus #(.W(DW), .N(RD_SRC)) u_bus_a (
        .clk   (clk),
        .rst   (rst),
        .en_i  ({r1_rda_i, r0_rda_i}),
        .src_i ({regs_q.r1, regs_q.r0}),
        .bus_o (bus_a)
    );

    tbd_bus #(.W(DW), .N(RD_SRC)) u_bus_b (
        .clk   (clk),
        .rst   (rst),
        .en_i  ({r1_rdb_i, r0_rdb_i}),
        .src_i ({regs_q.r1, regs_q.r0}),
        .bus_o (bus_b)
    );

    tbd_bus #(.W(DW), .N(Z_SRC)) u_bus_z (
        .clk   (clk),
        .rst   (rst),
        .en_i  (z_en),
        .src_i (z_src),
        .bus_o (bus_z)
    );

    // read stage: a one-source holding bus from A to the pins
    tbd_bus #(.W(DW), .N(1)) u_rd_stage (
        .clk   (clk),
        .rst   (rst),
        .en_i  (ext_rd_i),
        .src_i (bus_a),
        .bus_o (ext_q_o)
    );

    tbd_funcunit #(.W(DW)) u_fn (
        .a_i   (bus_a),
        .b_i   (bus_b),
        .sel_i (fn_sel_i),
        .y_o   (fn_y)
    );

    tbd_shifter #(.W(DW)) u_sh (
        .a_i    (bus_a),
        .on_i   (sh_on_i),
        .left_i (sh_left_i),
        .y_o    (sh_y)
    );

    tbd_addsub #(.W(DW)) u_as (
        .a_i   (bus_a),
        .b_i   (bus_b),
        .sub_i (sub_i),
        .y_o   (as_y)
    );

    always_comb begin
        regs_d = regs_q;
        if (r0_wr_i) regs_d.r0 = bus_z;
        if (r1_wr_i) regs_d.r1 = bus_z;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    // R2
    reg0_write_chk: assert property (@(posedge clk) disable iff (rst)
        r0_wr_i |=> (regs_q.r0 == $past(bus_z)));

    // R2
    reg1_write_chk: assert property (@(posedge clk) disable iff (rst)
        r1_wr_i |=> (regs_q.r1 == $past(bus_z)));

    // R2
    reg_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!r0_wr_i && !r1_wr_i) |=> $stable(regs_q));

    // R3
    read_a_chk: assert property (@(posedge clk) disable iff (rst)
        (r0_rda_i && !r1_rda_i) |-> (bus_a == regs_q.r0));

    // R3
    read_b_chk: assert property (@(posedge clk) disable iff (rst)
        (r1_rdb_i && !r0_rdb_i) |-> (bus_b == regs_q.r1));

    // R6
    out_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ext_rd_i |-> (ext_q_o == bus_a));
endmodule

// File: tb/test_tbd_datapath.sv
module test_tbd_datapath;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ext_d;
    logic [7:0] ext_q;
    logic [3:0] fn_sel;
    logic fn_en, sh_on, sh_left, sh_en, sub, as_en;
    logic r0_wr, r0_rda, r0_rdb, r1_wr, r1_rda, r1_rdb, ext_ld, ext_rd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    logic [7:0] m_r0 = '0, m_r1 = '0, m_ah = '0, m_bh = '0, m_zh = '0, m_oh = '0;

    always #(CLK_P/2) clk = ~clk;

    tbd_datapath i_tbd_datapath (
        .clk(clk), .rst(rst), .ext_d_i(ext_d), .ext_q_o(ext_q),
        .fn_sel_i(fn_sel), .fn_en_i(fn_en), .sh_on_i(sh_on), .sh_left_i(sh_left),
        .sh_en_i(sh_en), .sub_i(sub), .as_en_i(as_en),
        .r0_wr_i(r0_wr), .r0_rda_i(r0_rda), .r0_rdb_i(r0_rdb),
        .r1_wr_i(r1_wr), .r1_rda_i(r1_rda), .r1_rdb_i(r1_rdb),
        .ext_ld_i(ext_ld), .ext_rd_i(ext_rd)
    );

    function automatic logic [7:0] fn_ref(input logic [7:0] a, input logic [7:0] b,
                                          input logic [3:0] g);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = g[{a[i], b[i]}];
        return r;
    endfunction

    function automatic logic [7:0] sh_ref(input logic [7:0] a, input logic on, input logic lft);
        if (!on) return a;
        return lft ? (a << 1) : (a >> 1);
    endfunction

    function automatic logic [7:0] as_ref(input logic [7:0] a, input logic [7:0] b, input logic s);
        return s ? 8'(a - b) : 8'(a + b);
    endfunction

    task automatic clear_ctl();
        {fn_en, sh_on, sh_left, sh_en, sub, as_en} = '0;
        {r0_wr, r0_rda, r0_rdb, r1_wr, r1_rda, r1_rdb, ext_ld, ext_rd} = '0;
        fn_sel = 4'h0;
        ext_d  = 8'h00;
    endtask

    // called just after a falling edge with controls set
    task automatic tick(input string tag);
        logic [7:0] a, b, z, o;
        a = r0_rda ? m_r0 : (r1_rda ? m_r1 : m_ah);
        b = r0_rdb ? m_r0 : (r1_rdb ? m_r1 : m_bh);
        z = fn_en ? fn_ref(a, b, fn_sel) :
            sh_en ? sh_ref(a, sh_on, sh_left) :
            as_en ? as_ref(a, b, sub) :
            ext_ld ? ext_d : m_zh;
        o = ext_rd ? a : m_oh;
        #(CLK_P/4);
        checks++;
        if (ext_q !== o) begin
            fails++;
            $display("FAIL %s: ext_q actual %h expected %h", tag, ext_q, o);
        end
        @(posedge clk);
        if (r0_wr) m_r0 = z;
        if (r1_wr) m_r1 = z;
        m_ah = a; m_bh = b; m_zh = z; m_oh = o;
        @(negedge clk);
        clear_ctl();
    endtask

    task automatic read_reg(input bit which, input string tag);
        if (which) r1_rda = 1'b1; else r0_rda = 1'b1;
        ext_rd = 1'b1;
        tick(tag);
    endtask

    task automatic load_reg(input bit which, input logic [7:0] v, input string tag);
        ext_ld = 1'b1; ext_d = v;
        if (which) r1_wr = 1'b1; else r0_wr = 1'b1;
        tick(tag);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        clear_ctl();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state seen through an idle read
        ext_rd = 1'b1; tick("R1");

        // R5 / R2: constants into both registers, read back (R3, R6)
        load_reg(1'b0, 8'h3C, "R5");
        load_reg(1'b1, 8'hA5, "R5");
        read_reg(1'b0, "R2");
        read_reg(1'b1, "R3");
        // R6: output holds with read enable low
        tick("R6");
        // R4: undriven A held, then undriven Z written into register 0
        ext_rd = 1'b1; tick("R4");
        load_reg(1'b0, 8'h5A, "R5");
        r1_wr = 1'b1; tick("R4");
        read_reg(1'b1, "R4");
        // R2: no write keeps contents
        tick("R2");
        read_reg(1'b0, "R2");

        // R7: add and subtract, with wrap
        load_reg(1'b0, 8'hF0, "R7");
        load_reg(1'b1, 8'h25, "R7");
        r0_rda = 1'b1; r1_rdb = 1'b1; as_en = 1'b1; r0_wr = 1'b1; tick("R7");
        read_reg(1'b0, "R7");
        r1_rda = 1'b1; r0_rdb = 1'b1; as_en = 1'b1; sub = 1'b1; r1_wr = 1'b1; tick("R7");
        read_reg(1'b1, "R7");

        // R8: shift left, right, pass
        load_reg(1'b0, 8'h81, "R8");
        r0_rda = 1'b1; sh_en = 1'b1; sh_on = 1'b1; sh_left = 1'b1; r0_wr = 1'b1; tick("R8");
        read_reg(1'b0, "R8");
        r0_rda = 1'b1; sh_en = 1'b1; sh_on = 1'b1; r1_wr = 1'b1; tick("R8");
        read_reg(1'b1, "R8");
        r1_rda = 1'b1; sh_en = 1'b1; r0_wr = 1'b1; tick("R8");
        read_reg(1'b0, "R8");

        // R9: several truth tables
        foreach (fn_sel_list[k]) begin
            load_reg(1'b0, 8'hCA, "R9");
            load_reg(1'b1, 8'h6C, "R9");
            r0_rda = 1'b1; r1_rdb = 1'b1; fn_en = 1'b1; fn_sel = fn_sel_list[k];
            r0_wr = 1'b1; ext_rd = 1'b1; tick("R9");
            read_reg(1'b0, "R9");
        end

        // R10: random single-driver micro-operations
        for (int it = 0; it < 400; it++) begin
            int za, zb, zz;
            za = int'($urandom_range(2));
            zb = int'($urandom_range(2));
            zz = int'($urandom_range(4));
            r0_rda = (za == 1); r1_rda = (za == 2);
            r0_rdb = (zb == 1); r1_rdb = (zb == 2);
            fn_en = (zz == 1); sh_en = (zz == 2); as_en = (zz == 3); ext_ld = (zz == 4);
            fn_sel = 4'($urandom); sh_on = 1'($urandom); sh_left = 1'($urandom);
            sub = 1'($urandom); ext_d = 8'($urandom);
            r0_wr = 1'($urandom); r1_wr = 1'($urandom); ext_rd = 1'($urandom);
            tick("R10");
        end
        read_reg(1'b0, "R10");
        read_reg(1'b1, "R10");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // AND, XOR, OR, NOR, pass A
    logic [3:0] fn_sel_list [5] = '{4'b1000, 4'b0110, 4'b1110, 4'b0001, 4'b1100};
endmodule